// File: doc/BRIEF.md
# Rotating Four-Bank Sector Streamer

This block carries a run of consecutive sectors out of a flash page through four rotating bank buffers. Each sector is 512 data bytes followed by 16 metadata bytes. The block keeps the two sides apart. The flash side fills one bank from a byte stream and signals the end of each fill. The consumer side reads a finished bank out as a valid/ready byte stream. Because the block launches the next fill before it releases the bank that has just been filled, reading and filling overlap.

A run starts with a one-cycle `start` pulse. The pulse carries a sector count and a checksum-enable bit, which the block captures. The scheduler is a state machine with five states.
- `ST_IDLE` waits for `start`. It goes to `ST_ARM`, or straight to `ST_FINISH` when the count is zero.
- `ST_ARM` selects the chip and raises the checksum enable for one cycle before any fill. It then goes to `ST_LAUNCH`.
- `ST_LAUNCH` issues a fill command once the target bank is free. It then goes to `ST_WAIT`.
- `ST_WAIT` waits for the fill-done indication. It goes back to `ST_LAUNCH` while sectors remain, or to `ST_FINISH` after the last fill.
- `ST_FINISH` waits until every sector has been read out. It then pulses `done` and returns to `ST_IDLE`.

Checksum or error-correction decoding is not part of this block. The enable bit is only passed on in each fill command.

Top module: `sector_stream`

## Requirements
- R1: After reset, `out_valid`, `fill_go`, `chip_sel`, `chk_en` and `done` are all low.
- R2: A `start` with a sector count of zero issues no fill and never raises `chip_sel`. It pulses `done` once, in the cycle after `start` is sampled.
- R3: `chip_sel` and `chk_en` are high for at least one cycle before the first `fill_go`. The `chk_en` output and bit 0 of `fill_word` carry the enable value captured at `start`. Later changes of `ecc_en` during the run have no effect.
- R4: Fills are issued in sector order. The first fill of a run targets bank 0. The fill for sector k targets bank k mod 4, and the bank number is placed in bits [4:3] of `fill_word`.
- R5: Sector k, when it is not the last sector, is not read out before the fill for sector k+1 has been issued. The last sector is read out only after its own fill has completed.
- R6: Each sector leaves on the output stream in the order written. The 512 data bytes come first with `out_meta` low, then the 16 metadata bytes with `out_meta` high. `out_last` is high on the final metadata byte only.
- R7: A fill is never issued into a bank that still holds a sector not yet fully read out. At most four sectors are ever pending, and a launch waits while the consumer stalls.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` and `out_meta` stay unchanged.
- R9: `done` is high for exactly one cycle, in the cycle right after the final metadata byte is accepted. `chip_sel` is low in the cycle after `done`.
- R10: A `start` pulse during a run is ignored. The number of fills issued and of sectors delivered is the count captured first.
- R11: No fill is issued while the previous fill is still receiving bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| sec_count | input | CNT_W | Number of sectors in the run, sampled with `start` |
| ecc_en | input | 1 | Checksum enable, sampled with `start` |
| fill_go | output | 1 | Fill command strobe, accepted at the clock edge |
| fill_word | output | 8 | Fill command: bank in [4:3], checksum enable in [0] |
| chip_sel | output | 1 | Flash chip select, high during a non-empty run |
| chk_en | output | 1 | Checksum enable towards the flash side |
| fill_valid | input | 1 | Fill byte strobe |
| fill_byte | input | 8 | Fill byte, data first then metadata |
| fill_done | input | 1 | Current fill has completed |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| out_meta | output | 1 | Output byte belongs to the metadata part |
| out_last | output | 1 | Output byte is the last one of its sector |
| done | output | 1 | Run complete, one-cycle pulse |

## Verification
Two events can fall on the same clock edge. One is the acceptance of a sector's final byte, which frees a bank. The other is the scheduler's decision to launch into that same bank. The bench holds the consumer stalled for longer than four fills take, so the fifth launch has to wait. It then releases the consumer, so the freeing handshake and the launch decision land together. At every fill command the bench counts the sectors issued but not yet fully read out, and the count must stay below four. The scoreboard confirms that no byte of the bank being refilled was overwritten before it was read out.

// File: rtl/sstr_pkg.sv
package sstr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_LAUNCH,
        ST_WAIT,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/sstr_seq.sv
module sstr_seq
    import sstr_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int NBANK = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CNT_W-1:0]         sec_count,
    input  logic                     ecc_en,
    input  logic                     fill_done,
    input  logic                     sec_drained,
    output logic                     fill_go,
    output logic [7:0]               fill_word,
    output logic                     chip_sel,
    output logic                     chk_en,
    output logic                     release_sec,
    output logic [$clog2(NBANK)-1:0] drain_bank,
    output logic                     done
);
    localparam int BANK_W = $clog2(NBANK);

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] cnt_r, launched, drained;
    logic             ecc_r;
    logic             bank_room;

    assign bank_room  = (launched - drained) < CNT_W'(NBANK);
    assign drain_bank = drained[BANK_W-1:0];
    assign chip_sel   = (state != ST_IDLE) && (cnt_r != '0);
    assign chk_en     = chip_sel && ecc_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt_r    <= '0;
            launched <= '0;
            drained  <= '0;
            ecc_r    <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                cnt_r    <= sec_count;
                ecc_r    <= ecc_en;
                launched <= '0;
                drained  <= '0;
            end else begin
                if (fill_go)     launched <= launched + 1'b1;
                if (sec_drained) drained  <= drained + 1'b1;
            end
        end
    end

    always_comb begin
        nxt         = state;
        fill_go     = 1'b0;
        release_sec = 1'b0;
        done        = 1'b0;
        fill_word   = '0;
        fill_word[3 +: BANK_W] = launched[BANK_W-1:0];
        fill_word[0]           = ecc_r;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = (sec_count == '0) ? ST_FINISH : ST_ARM;
            end
            ST_ARM: nxt = ST_LAUNCH;
            ST_LAUNCH: begin
                if (bank_room) begin
                    fill_go     = 1'b1;
                    release_sec = (launched != '0);
                    nxt         = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (fill_done) begin
                    if (launched == cnt_r) begin
                        release_sec = 1'b1;
                        nxt         = ST_FINISH;
                    end else begin
                        nxt = ST_LAUNCH;
                    end
                end
            end
            ST_FINISH: begin
                if (drained == cnt_r) begin
                    done = 1'b1;
                    nxt  = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R3: the chip is selected at least a cycle before the first fill
    a_r3_arm_before_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && launched == '0) |-> $past(chip_sel));

    // R9: deselect follows completion
    a_r9_deselect_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !chip_sel);

    // R10: the captured count is held while a run is active
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(cnt_r));
endmodule

// File: rtl/sstr_fill.sv
module sstr_fill #(
    parameter int SEC_BYTES = 528,
    parameter int NBANK     = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             fill_go,
    input  logic [$clog2(NBANK)-1:0]         fill_bank,
    input  logic                             fill_valid,
    input  logic [7:0]                       fill_byte,
    input  logic                             fill_done,
    output logic                             fill_active,
    output logic                             wr_en,
    output logic [$clog2(NBANK)-1:0]         wr_bank,
    output logic [$clog2(SEC_BYTES+1)-1:0]   wr_off,
    output logic [7:0]                       wr_byte
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int OFF_W  = $clog2(SEC_BYTES + 1);

    logic              active;
    logic [BANK_W-1:0] bank_r;
    logic [OFF_W-1:0]  ptr;

    assign fill_active = active;
    assign wr_en       = active && fill_valid && (ptr < OFF_W'(SEC_BYTES));
    assign wr_bank     = bank_r;
    assign wr_off      = ptr;
    assign wr_byte     = fill_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            bank_r <= '0;
            ptr    <= '0;
        end else if (fill_go) begin
            active <= 1'b1;
            bank_r <= fill_bank;
            ptr    <= '0;
        end else if (fill_done) begin
            active <= 1'b0;
        end else if (wr_en) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/sstr_banks.sv
module sstr_banks #(
    parameter int DATA_BYTES = 512,
    parameter int META_BYTES = 16,
    parameter int NBANK      = 4
) (
    input  logic                                         clk,
    input  logic                                         wr_en,
    input  logic [$clog2(NBANK)-1:0]                     wr_bank,
    input  logic [$clog2(DATA_BYTES+META_BYTES+1)-1:0]   wr_off,
    input  logic [7:0]                                   wr_byte,
    input  logic [$clog2(NBANK)-1:0]                     rd_bank,
    input  logic [$clog2(DATA_BYTES+META_BYTES+1)-1:0]   rd_off,
    output logic [7:0]                                   rd_byte
);
    localparam int OFF_W  = $clog2(DATA_BYTES + META_BYTES + 1);
    localparam int DOFF_W = $clog2(DATA_BYTES);
    localparam int MOFF_W = $clog2(META_BYTES);

    logic [7:0] dmem [NBANK*DATA_BYTES];
    logic [7:0] mmem [NBANK*META_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_off < OFF_W'(DATA_BYTES))
                dmem[{wr_bank, wr_off[DOFF_W-1:0]}] <= wr_byte;
            else
                mmem[{wr_bank, wr_off[MOFF_W-1:0]}] <= wr_byte;
        end
    end

    always_comb begin
        if (rd_off < OFF_W'(DATA_BYTES))
            rd_byte = dmem[{rd_bank, rd_off[DOFF_W-1:0]}];
        else
            rd_byte = mmem[{rd_bank, rd_off[MOFF_W-1:0]}];
    end
endmodule

// File: rtl/sstr_drain.sv
module sstr_drain #(
    parameter int DATA_BYTES = 512,
    parameter int META_BYTES = 16,
    parameter int CNT_W      = 12
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        release_sec,
    input  logic                                        out_ready,
    output logic [$clog2(DATA_BYTES+META_BYTES+1)-1:0]  rd_off,
    output logic                                        out_valid,
    output logic                                        out_meta,
    output logic                                        out_last,
    output logic                                        sec_drained
);
    localparam int SEC_BYTES = DATA_BYTES + META_BYTES;
    localparam int OFF_W     = $clog2(SEC_BYTES + 1);

    logic             active;
    logic [OFF_W-1:0] off;
    logic [CNT_W-1:0] pend;
    logic             take;

    assign take        = !active && (pend != '0);
    assign rd_off      = off;
    assign out_valid   = active;
    assign out_meta    = active && (off >= OFF_W'(DATA_BYTES));
    assign out_last    = active && (off == OFF_W'(SEC_BYTES - 1));
    assign sec_drained = out_valid && out_ready && (off == OFF_W'(SEC_BYTES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            off    <= '0;
            pend   <= '0;
        end else begin
            pend <= pend + CNT_W'(release_sec) - CNT_W'(take);
            if (take) begin
                active <= 1'b1;
                off    <= '0;
            end else if (active && out_ready) begin
                if (off == OFF_W'(SEC_BYTES - 1)) active <= 1'b0;
                else                              off    <= off + 1'b1;
            end
        end
    end

    // R6: the last byte of a sector belongs to the metadata part
    a_r6_last_is_meta: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_meta);
endmodule

// File: rtl/sector_stream.sv
module sector_stream #(
    parameter int DATA_BYTES = 512,
    parameter int META_BYTES = 16,
    parameter int NBANK      = 4,
    parameter int CNT_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] sec_count,
    input  logic             ecc_en,
    output logic             fill_go,
    output logic [7:0]       fill_word,
    output logic             chip_sel,
    output logic             chk_en,
    input  logic             fill_valid,
    input  logic [7:0]       fill_byte,
    input  logic             fill_done,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_meta,
    output logic             out_last,
    output logic             done
);
    localparam int BANK_W    = $clog2(NBANK);
    localparam int SEC_BYTES = DATA_BYTES + META_BYTES;
    localparam int OFF_W     = $clog2(SEC_BYTES + 1);

    logic              release_sec, sec_drained, fill_active, wr_en;
    logic [BANK_W-1:0] drain_bank, wr_bank;
    logic [OFF_W-1:0]  wr_off, rd_off;
    logic [7:0]        wr_byte;

    sstr_seq #(.CNT_W(CNT_W), .NBANK(NBANK)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .sec_count(sec_count),
        .ecc_en(ecc_en), .fill_done(fill_done), .sec_drained(sec_drained),
        .fill_go(fill_go), .fill_word(fill_word), .chip_sel(chip_sel),
        .chk_en(chk_en), .release_sec(release_sec), .drain_bank(drain_bank),
        .done(done)
    );

    sstr_fill #(.SEC_BYTES(SEC_BYTES), .NBANK(NBANK)) u_fill (
        .clk(clk), .rst_n(rst_n), .fill_go(fill_go),
        .fill_bank(fill_word[3 +: BANK_W]), .fill_valid(fill_valid),
        .fill_byte(fill_byte), .fill_done(fill_done), .fill_active(fill_active),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_off(wr_off), .wr_byte(wr_byte)
    );

    sstr_banks #(.DATA_BYTES(DATA_BYTES), .META_BYTES(META_BYTES), .NBANK(NBANK)) u_banks (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_off(wr_off),
        .wr_byte(wr_byte), .rd_bank(drain_bank), .rd_off(rd_off), .rd_byte(out_data)
    );

    sstr_drain #(.DATA_BYTES(DATA_BYTES), .META_BYTES(META_BYTES), .CNT_W(CNT_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .release_sec(release_sec), .out_ready(out_ready),
        .rd_off(rd_off), .out_valid(out_valid), .out_meta(out_meta),
        .out_last(out_last), .sec_drained(sec_drained)
    );

    // R11: a new fill command never interrupts a fill in progress
    a_r11_no_launch_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |-> !fill_active);

    // R8: output held stable under back-pressure
    a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_meta)));

    // R9: completion only when nothing is left to deliver
    a_r9_done_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);
endmodule

// File: tb/sector_stream_test.sv
module sector_stream_test;
    localparam int CLK_NS = 10;
    localparam int DATA   = 512;
    localparam int SEC    = 528;
    localparam int CNT_W  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] sec_count = '0;
    logic             ecc_en = 1'b0;
    logic             fill_go, chip_sel, chk_en;
    logic [7:0]       fill_word;
    logic             fill_valid = 1'b0;
    logic [7:0]       fill_byte = '0;
    logic             fill_done = 1'b0;
    logic             out_valid, out_meta, out_last, done;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;

    sector_stream uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sec_count(sec_count),
        .ecc_en(ecc_en), .fill_go(fill_go), .fill_word(fill_word),
        .chip_sel(chip_sel), .chk_en(chk_en), .fill_valid(fill_valid),
        .fill_byte(fill_byte), .fill_done(fill_done), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_meta(out_meta),
        .out_last(out_last), .done(done)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    int  run_n = 0, launches = 0, fills_done = 0, drained_secs = 0;
    int  mon_pos = 0, mon_sec = 0, done_seen = 0;
    int  rdy_mode = 0, stall_left = 0, cyc = 0;
    bit  expect_done = 0, zero_mode = 0, chk_desel = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor and consumer
    always @(negedge clk) begin
        if (rst_n) begin
            logic r;
            logic [7:0] e;
            cyc++;
            case (rdy_mode)
                0: r = 1'b1;
                1: r = ((cyc % 5) != 2);
                default: begin
                    if (stall_left > 0) begin stall_left--; r = 1'b0; end
                    else r = 1'b1;
                end
            endcase
            out_ready = r;
            if (chk_desel) begin
                check(!chip_sel, "R9 chip_sel after done", int'(chip_sel), 0);
                chk_desel = 0;
            end
            if (expect_done) begin
                check(done === 1'b1, "R9 done after final byte", int'(done), 1);
                expect_done = 0;
            end else if (done && !zero_mode) begin
                check(0, "R9 spurious done", 1, 0);
            end
            if (done) begin done_seen++; chk_desel = 1; end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected output byte", int'(out_data), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(out_data == e, "R6 byte value", int'(out_data), int'(e));
                    check(out_meta == (mon_pos >= DATA), "R6 meta flag", int'(out_meta), int'(mon_pos >= DATA));
                    check(out_last == (mon_pos == SEC-1), "R6 last flag", int'(out_last), int'(mon_pos == SEC-1));
                    if (mon_pos == 0) begin
                        if (mon_sec < run_n - 1)
                            check(launches >= mon_sec + 2, "R5 next fill issued before drain", launches, mon_sec + 2);
                        else
                            check(fills_done >= run_n, "R5 last fill complete before drain", fills_done, run_n);
                    end
                    mon_pos++;
                    if (mon_pos == SEC) begin
                        mon_pos = 0;
                        mon_sec++;
                        drained_secs++;
                        if (mon_sec == run_n) expect_done = 1;
                    end
                end
            end
        end
    end

    // flash-side model: answers each fill command with one sector of bytes
    task automatic flash_run(input int n, input int ecc, input int seed);
        bit seen_sel = 0;
        for (int s = 0; s < n; s++) begin
            while (!fill_go) begin
                seen_sel |= chip_sel;
                @(negedge clk);
            end
            launches++;
            check(int'(fill_word[4:3]) == (s % 4), "R4 bank field", int'(fill_word[4:3]), s % 4);
            check(int'(fill_word[0]) == ecc, "R3 enable bit in command", int'(fill_word[0]), ecc);
            check(int'(chk_en) == ecc, "R3 chk_en value", int'(chk_en), ecc);
            check((s - drained_secs) < 4, "R7 pending sectors at launch", s - drained_secs, 3);
            if (s == 0) check(seen_sel, "R3 select before first fill", int'(seen_sel), 1);
            @(negedge clk);
            for (int i = 0; i < SEC; i++) begin
                if (((i * 7 + s) % 11) == 0) begin
                    fill_valid = 1'b0;
                    @(negedge clk);
                end
                fill_valid = 1'b1;
                fill_byte  = 8'((s * 37 + i * 5 + seed) & 255);
                exp_q.push_back(fill_byte);
                @(negedge clk);
            end
            fill_valid = 1'b0;
            fill_done  = 1'b1;
            fills_done++;
            @(negedge clk);
            fill_done = 1'b0;
        end
    endtask

    task automatic run(input int n, input int ecc, input int mode, input int stall, input bit poke);
        launches = 0; fills_done = 0; drained_secs = 0;
        mon_pos = 0; mon_sec = 0; done_seen = 0; run_n = n;
        rdy_mode = mode; stall_left = stall;
        @(negedge clk);
        sec_count = CNT_W'(n);
        ecc_en    = ecc[0];
        start     = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        ecc_en = ~ecc[0];
        fork
            flash_run(n, ecc, n * 13);
        join_none
        if (poke) begin
            repeat (40) @(negedge clk);
            sec_count = CNT_W'(2);
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_seen == 0) @(negedge clk);
        repeat (30) @(negedge clk);
        check(launches == n, "R10 fills issued equals captured count", launches, n);
        check(mon_sec == n, "R10 sectors delivered", mon_sec, n);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        check(done_seen == 1, "R9 single done pulse", done_seen, 1);
        check(!out_valid && !fill_go, "R10 quiet after run", int'(out_valid || fill_go), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !fill_go && !chip_sel && !chk_en && !done, "R1 reset outputs",
              int'({out_valid, fill_go, chip_sel, chk_en, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !fill_go && !chip_sel && !done, "R1 after reset release",
              int'({out_valid, fill_go, chip_sel, done}), 0);

        // R2: empty run
        zero_mode = 1;
        sec_count = '0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, "R2 done in cycle after start", int'(done), 1);
        for (int k = 0; k < 6; k++) begin
            check(!fill_go && !chip_sel, "R2 no fill or select", int'({fill_go, chip_sel}), 0);
            @(negedge clk);
        end
        check(done_seen == 1, "R2 exactly one done", done_seen, 1);
        zero_mode = 0;

        run(1, 1, 0, 0, 0);      // single sector, enable on
        run(6, 0, 1, 0, 0);      // bank wrap, intermittent consumer
        run(9, 1, 2, 3000, 1);   // long stall forces bank-free wait, stray start

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule